// File: doc/BRIEF.md
# Processor Power-Down Sequencer

This block sits next to a processor core and parks it in one of three sleep levels. Software writes a six-bit sleep field that the core maps into bits 15 to 10 of its control/status word. The top bit of that field is reserved, so it has no write lane and always reads back as 0. The next two bits choose which interrupts may end the light level. The lowest three bits request the light, middle and deep levels.

Once a sleep request is accepted, the sequencer waits a fixed number of clock cycles and then raises its gating outputs:

- The light level raises only the core stall.
- The middle level also gates the core clock tree.
- The deep level also gates the peripherals.

From the light level the sequencer watches the interrupt lines. When a permitted interrupt arrives, it issues a one-cycle resume pulse together with a flag that tells the core whether to enter the interrupt service routine first. The middle and deep levels stay asleep until device reset.

An interrupt that shows up while the entry delay is still counting is remembered. It is evaluated as soon as the sleep level becomes active.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, the read-back field is 0 and `core_stall`, `clk_gate`, `periph_gate`, `resume_pulse` and `take_isr` are all 0.
- R2: A write stores `fld_wdata` into read-back bits [4:0]. Read-back bit 5 (reserved) is always 0. The field layout is: bit 4 wakes on any interrupt, bit 3 wakes on an enabled interrupt, and bits 2, 1 and 0 request the deep, middle and light level.
- R3: If a write with at least one level bit set is sampled at clock edge E0, `core_stall` rises right after edge E0+ENTRY_DLY (default 8, legal 8 or 9) and not before. A write with no level bit set never stalls the core.
- R4: When several level bits are set, deep wins over middle and middle wins over light. The outputs while asleep are: light gives `core_stall` only; middle gives `core_stall` and `clk_gate`; deep gives `core_stall`, `clk_gate` and `periph_gate`.
- R5: With field bit 4 set, any `irq_req` bit ends the light level. An interrupt whose `irq_en` bit is clear gives `take_isr` = 0.
- R6: With field bit 3 set and bit 4 clear, interrupts whose `irq_en` bit is clear leave the core asleep, and an enabled interrupt ends the light level.
- R7: `take_isr` is 1 at the resume only when an enabled interrupt is present and both `gie` and `nmie` are 1 in the wake cycle. Otherwise it is 0.
- R8: Leaving the light level drives `resume_pulse` high for exactly one cycle, in the first cycle in which `core_stall` is low. It also clears read-back bit 0.
- R9: In the middle and deep levels no interrupt pattern ends sleep. Only `rst_n` does.
- R10: An interrupt pulse seen during the entry delay ends the light level on its first sleeping cycle, so `core_stall` is high for exactly one cycle.
- R11: A write presented while a sleep is arming or active is ignored. The read-back value and the scheduled entry are unchanged.
- R12: A light-level request with both wake bits clear stays asleep through interrupts until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low device reset |
| fld_we | input | 1 | Write strobe for the sleep field |
| fld_wdata | input | 5 | Written field bits 4..0 (wake-any, wake-enabled, deep, middle, light) |
| fld_rdata | output | 6 | Read-back field, bit 5 reserved and 0 |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| gie | input | 1 | Global interrupt enable |
| nmie | input | 1 | NMI enable |
| core_stall | output | 1 | Core stalled in any sleep level |
| clk_gate | output | 1 | Core clock tree gated (middle and deep) |
| periph_gate | output | 1 | Peripherals gated (deep) |
| resume_pulse | output | 1 | One-cycle resume from the light level |
| take_isr | output | 1 | Valid with resume: vector to the interrupt first |

## Verification
The bench measures the entry point to the exact cycle. A counter that is off by one would raise the stall one edge early or late. It sets up wake-select and enable combinations in which a sequencer that ignored the enable line would wake on a disabled interrupt, or would grant the service routine without both global enables. It pulses an interrupt inside the entry window: a design that forgot it would sleep forever, while one that let it abort entry would never stall. It also floods the middle and deep levels, a middle-over-light request, and a light request with no wake bits with interrupts, where any resume is a defect, and it writes during arming, which a careless design would let retarget the sleep level.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef struct packed {
    logic rsvd;
    logic wake_any;
    logic wake_en;
    logic lvl_deep;
    logic lvl_mid;
    logic lvl_light;
  } pd_field_t;

  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_LIGHT = 2'd1,
    LVL_MID   = 2'd2,
    LVL_DEEP  = 2'd3
  } pd_level_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ARM   = 2'd1,
    ST_SLEEP = 2'd2
  } pd_state_e;

  // build the stored field from a write; reserved lane is always zero
  function automatic pd_field_t pack_write(logic [4:0] w);
    pd_field_t f;
    f = {1'b0, w};
    return f;
  endfunction

  // deepest requested level wins
  function automatic pd_level_e pick_level(pd_field_t f);
    if (f.lvl_deep)       return LVL_DEEP;
    else if (f.lvl_mid)   return LVL_MID;
    else if (f.lvl_light) return LVL_LIGHT;
    else                  return LVL_NONE;
  endfunction

  function automatic logic wake_hit(pd_field_t f, logic any_src, logic en_src);
    return (f.wake_any & any_src) | (f.wake_en & en_src);
  endfunction

  function automatic logic isr_granted(logic en_src, logic g_en, logic n_en);
    return en_src & g_en & n_en;
  endfunction

endpackage

// File: rtl/pwrdn_field_reg.sv
module pwrdn_field_reg
  import pwrdn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ok,
  input  logic [4:0] wr_field,
  input  logic      clr_light,
  output pd_field_t fld_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fld_q <= '0;
    else if (wr_ok)      fld_q <= pack_write(wr_field);
    else if (clr_light)  fld_q.lvl_light <= 1'b0;
  end

endmodule

// File: rtl/pwrdn_entry_timer.sv
module pwrdn_entry_timer #(
  parameter int DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);

  localparam int CNT_W = $clog2(DLY + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DLY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = run_q && (cnt_q == '0);

endmodule

// File: rtl/pwrdn_wake_eval.sv
module pwrdn_wake_eval
  import pwrdn_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_pend,
  input  logic             arming,
  input  logic             sleeping_light,
  input  pd_field_t        fld,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic             nmie,
  output logic             wake_evt,
  output logic             isr_go
);

  logic pend_any_q, pend_en_q;
  logic any_now, en_now, any_src, en_src;

  assign any_now = |irq_req;
  assign en_now  = |(irq_req & irq_en);

  // interrupts seen while the entry delay runs are held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_any_q <= 1'b0;
      pend_en_q  <= 1'b0;
    end else if (clr_pend) begin
      pend_any_q <= 1'b0;
      pend_en_q  <= 1'b0;
    end else if (arming) begin
      pend_any_q <= pend_any_q | any_now;
      pend_en_q  <= pend_en_q  | en_now;
    end
  end

  assign any_src  = any_now | pend_any_q;
  assign en_src   = en_now  | pend_en_q;
  assign wake_evt = sleeping_light && wake_hit(fld, any_src, en_src);
  assign isr_go   = isr_granted(en_src, gie, nmie);

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int N_IRQ     = 4,
  parameter int ENTRY_DLY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fld_we,
  input  logic [4:0]       fld_wdata,
  output logic [5:0]       fld_rdata,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic             nmie,
  output logic             core_stall,
  output logic             clk_gate,
  output logic             periph_gate,
  output logic             resume_pulse,
  output logic             take_isr
);

  pd_state_e state_q, state_d;
  pd_field_t fld_q;
  pd_level_e cur_lvl;

  // named internal events, brought out for the checker
  logic wr_accept;
  logic start_entry;
  logic entry_expire;
  logic wake_evt;
  logic isr_go;
  logic sleeping;
  logic sleeping_light;
  logic resume_q, isr_q;

  assign wr_accept   = fld_we && (state_q == ST_RUN);
  assign start_entry = wr_accept && (pick_level(pack_write(fld_wdata)) != LVL_NONE);
  assign cur_lvl     = pick_level(fld_q);
  assign sleeping    = (state_q == ST_SLEEP);
  assign sleeping_light = sleeping && (cur_lvl == LVL_LIGHT);

  pwrdn_field_reg u_field (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (wr_accept),
    .wr_field  (fld_wdata),
    .clr_light (wake_evt),
    .fld_q     (fld_q)
  );

  pwrdn_entry_timer #(.DLY(ENTRY_DLY)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_entry),
    .expire (entry_expire)
  );

  pwrdn_wake_eval #(.N_IRQ(N_IRQ)) u_wake (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr_pend       (start_entry),
    .arming         (state_q == ST_ARM),
    .sleeping_light (sleeping_light),
    .fld            (fld_q),
    .irq_req        (irq_req),
    .irq_en         (irq_en),
    .gie            (gie),
    .nmie           (nmie),
    .wake_evt       (wake_evt),
    .isr_go         (isr_go)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:   if (start_entry)  state_d = ST_ARM;
      ST_ARM:   if (entry_expire) state_d = ST_SLEEP;
      ST_SLEEP: if (wake_evt)     state_d = ST_RUN;
      default:                    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      resume_q <= 1'b0;
      isr_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= wake_evt;
      isr_q    <= wake_evt && isr_go;
    end
  end

  assign fld_rdata    = fld_q;
  assign core_stall   = sleeping;
  assign clk_gate     = sleeping && (cur_lvl == LVL_MID || cur_lvl == LVL_DEEP);
  assign periph_gate  = sleeping && (cur_lvl == LVL_DEEP);
  assign resume_pulse = resume_q;
  assign take_isr     = isr_q;

endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
  parameter int ENTRY_DLY = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fld_we,
  input logic [5:0] fld_rdata,
  input logic       gie,
  input logic       nmie,
  input logic       core_stall,
  input logic       clk_gate,
  input logic       periph_gate,
  input logic       resume_pulse,
  input logic       take_isr,
  input logic       wr_accept,
  input logic       start_entry,
  input logic       wake_evt
);

  logic [7:0] since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_start <= 8'hFF;
    else if (start_entry)       since_start <= 8'd0;
    else if (since_start != 8'hFF) since_start <= since_start + 8'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (fld_rdata == 6'd0 && !core_stall && !resume_pulse && !take_isr));

  a_r3_entry_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_stall) |-> (since_start == 8'(ENTRY_DLY)));

  a_r4_periph_nested: assert property (@(posedge clk) disable iff (!rst_n)
    periph_gate |-> (clk_gate && core_stall));

  a_r4_clk_nested: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate |-> core_stall);

  a_r7_isr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    take_isr |-> (resume_pulse && $past(gie) && $past(nmie)));

  a_r8_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  a_r8_resume_ends_stall: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (!core_stall && $past(core_stall)));

  a_r9_deep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate |=> clk_gate);

  a_r11_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_we && !wr_accept && !wake_evt) |=> $stable(fld_rdata));

endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(.ENTRY_DLY(ENTRY_DLY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fld_we       (fld_we),
  .fld_rdata    (fld_rdata),
  .gie          (gie),
  .nmie         (nmie),
  .core_stall   (core_stall),
  .clk_gate     (clk_gate),
  .periph_gate  (periph_gate),
  .resume_pulse (resume_pulse),
  .take_isr     (take_isr),
  .wr_accept    (wr_accept),
  .start_entry  (start_entry),
  .wake_evt     (wake_evt)
);

// File: tb/pwrdn_ctrl_tb.sv
`timescale 1ns/1ps
module pwrdn_ctrl_tb;

  localparam int NI  = 4;
  localparam int DLY = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fld_we = 1'b0;
  logic [4:0]    fld_wdata = '0;
  logic [5:0]    fld_rdata;
  logic [NI-1:0] irq_req = '0;
  logic [NI-1:0] irq_en = '0;
  logic          gie = 1'b0;
  logic          nmie = 1'b0;
  logic          core_stall, clk_gate, periph_gate, resume_pulse, take_isr;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  string exp_req_q[$];
  logic  exp_isr_q[$];

  always #2 clk = ~clk;

  pwrdn_ctrl #(.N_IRQ(NI), .ENTRY_DLY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .fld_we(fld_we), .fld_wdata(fld_wdata),
    .fld_rdata(fld_rdata), .irq_req(irq_req), .irq_en(irq_en), .gie(gie),
    .nmie(nmie), .core_stall(core_stall), .clk_gate(clk_gate),
    .periph_gate(periph_gate), .resume_pulse(resume_pulse), .take_isr(take_isr)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: every resume pops one expected item and compares take_isr
  always @(negedge clk) begin
    if (rst_n && resume_pulse) begin
      if (exp_req_q.size() == 0) begin
        chk("R9", "unexpected resume", 1, 0);
      end else begin
        string r;
        logic  e;
        r = exp_req_q.pop_front();
        e = exp_isr_q.pop_front();
        chk(r, "take_isr at resume", int'(take_isr), int'(e));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [4:0] f);
    @(negedge clk);
    fld_we = 1'b1;
    fld_wdata = f;
    @(negedge clk);
    fld_we = 1'b0;
  endtask

  // write a request and verify the stall edge and gate pattern
  task automatic enter(string req, logic [4:0] f, int exp_cg, int exp_pg);
    int early = 0;
    wr(f);
    for (int k = 1; k <= DLY; k++) begin
      if (k > 1) ;
      @(negedge clk);
      if (k < DLY && core_stall) early = 1;
    end
    chk(req, "stall before delay", early, 0);
    chk(req, "core_stall at delay", int'(core_stall), 1);
    chk("R4", "clk_gate in sleep", int'(clk_gate), exp_cg);
    chk("R4", "periph_gate in sleep", int'(periph_gate), exp_pg);
  endtask

  task automatic wake(string req, logic [NI-1:0] irq, logic exp_isr);
    exp_req_q.push_back(req);
    exp_isr_q.push_back(exp_isr);
    irq_req = irq;
    @(negedge clk);
    chk(req, "resume_pulse after wake", int'(resume_pulse), 1);
    chk(req, "core_stall after wake", int'(core_stall), 0);
    irq_req = '0;
    @(negedge clk);
    chk("R8", "resume_pulse one cycle", int'(resume_pulse), 0);
  endtask

  task automatic flood(string req, int cycles);
    int woke = 0;
    irq_req = '1;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (!core_stall || resume_pulse) woke = 1;
    end
    irq_req = '0;
    chk(req, "woke under interrupts", woke, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rdata after reset", int'(fld_rdata), 0);
    chk("R1", "outputs after reset",
        int'({core_stall, clk_gate, periph_gate, resume_pulse, take_isr}), 0);

    // R2 write with no level bit; R3 no entry
    wr(5'b11000);
    chk("R2", "readback", int'(fld_rdata), 6'b011000);
    begin
      int st = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (core_stall) st = 1;
      end
      chk("R3", "stall without level bit", st, 0);
    end

    // R3/R5: light, wake on any, disabled interrupt
    gie = 1'b1; nmie = 1'b1; irq_en = 4'b0001;
    enter("R3", 5'b10001, 0, 0);
    wake("R5", 4'b0100, 1'b0);
    chk("R8", "light bit cleared", int'(fld_rdata), 6'b010000);

    // R6: wake on enabled only
    enter("R6", 5'b01001, 0, 0);
    irq_req = 4'b0100;
    repeat (6) @(negedge clk);
    chk("R6", "asleep with disabled irq", int'(core_stall), 1);
    irq_req = '0;
    wake("R6", 4'b0001, 1'b1);

    // R7: global or NMI enable clear
    gie = 1'b0;
    enter("R7", 5'b01001, 0, 0);
    wake("R7", 4'b0001, 1'b0);
    gie = 1'b1; nmie = 1'b0;
    enter("R7", 5'b01001, 0, 0);
    wake("R7", 4'b0001, 1'b0);
    nmie = 1'b1;

    // R5/R7: wake-any with an enabled interrupt takes the ISR
    enter("R5", 5'b10001, 0, 0);
    wake("R5", 4'b0001, 1'b1);

    // R11: write during arming is ignored
    wr(5'b10001);
    @(negedge clk);
    fld_we = 1'b1; fld_wdata = 5'b00010;
    @(negedge clk);
    fld_we = 1'b0;
    chk("R11", "readback after busy write", int'(fld_rdata), 6'b010001);
    for (int k = 3; k <= DLY; k++) @(negedge clk);
    chk("R11", "entry time kept", int'(core_stall), 1);
    chk("R11", "level kept light", int'(clk_gate), 0);
    wake("R5", 4'b0010, 1'b0);

    // R10: interrupt pulse inside the entry window
    exp_req_q.push_back("R10");
    exp_isr_q.push_back(1'b0);
    wr(5'b10001);
    @(negedge clk);
    irq_req = 4'b1000;
    @(negedge clk);
    irq_req = '0;
    for (int k = 3; k <= DLY; k++) @(negedge clk);
    chk("R10", "stall after delay", int'(core_stall), 1);
    @(negedge clk);
    chk("R10", "resume next cycle", int'(resume_pulse), 1);
    chk("R10", "stall one cycle", int'(core_stall), 0);

    // R12: light with no wake bits
    enter("R12", 5'b00001, 0, 0);
    flood("R12", 10);
    do_reset();
    chk("R1", "rdata after reset", int'(fld_rdata), 0);
    chk("R1", "stall after reset", int'(core_stall), 0);

    // R4/R9: all level bits, deep wins
    enter("R4", 5'b10111, 1, 1);
    chk("R9", "deep readback", int'(fld_rdata), 6'b010111);
    flood("R9", 20);
    chk("R9", "deep gates held", int'({clk_gate, periph_gate}), 3);
    do_reset();
    chk("R1", "gates after reset", int'({core_stall, clk_gate, periph_gate}), 0);

    // R4/R9: middle beats light
    enter("R4", 5'b10011, 1, 0);
    flood("R9", 20);
    do_reset();
    chk("R1", "rdata after reset", int'(fld_rdata), 0);

    chk("R8", "scoreboard drained", exp_req_q.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule